// File: doc/BRIEF.md
# Burst-Read Memory Responder

This block sits on the memory side of a synchronous bus and answers read requests that cover a whole number of four-word blocks. A master offers a start word address and a word count on the request port. The responder holds the bus for one address cycle and then waits out a long access delay for the first block. After that, each further block arrives at a short fixed interval. Each block is driven onto the return port for two cycles while the memory is already reading the next one. A short quiet period follows the final block, and only then does the responder take another request.

The timing is fixed and does not depend on the data, so one transaction's length follows from its word count alone. A cycle counter runs for the length of each accepted transaction and then holds its value. This lets a performance check read the total after the fact. The data comes from a small internal block-wide array that is filled with a computed pattern at start-up. If a request asks for zero words, or for a count that is not divisible by four, the responder flags an error and returns nothing.

Top module: `burst_rd_responder`

## Requirements
- R1: After reset, req_ready is 1 and busy, rsp_valid, rsp_last and req_err are 0, and cyc_count is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. For a valid count, busy is 1 and req_ready is 0 right after that edge, and both stay that way until the transaction ends. Requests offered while req_ready is 0 do not change the transaction in progress.
- R3: If the count is 0, or its two low bits are not 00, req_err is 1 for exactly the one cycle after the taking edge. In that case rsp_valid stays 0, busy stays 0, req_ready stays 1, and cyc_count keeps its value.
- R4: Call the taking edge edge 0. The first block is on the return port (rsp_valid = 1) after edges 41 and 42. This is one address cycle plus a 40-cycle first access.
- R5: Block k (counted from 0) is valid after edges 41+4k and 42+4k. rsp_data holds the same value on both of those cycles. rsp_valid is 0 on the two cycles between blocks.
- R6: rsp_data for block k holds the four words at word addresses B+4k to B+4k+3. B is req_addr with its two low bits cleared. Addresses wrap modulo 256. The lowest address sits in bits [31:0] and each next word sits 32 bits higher. The word at address a has the value a XOR 32'hC0DE0000.
- R7: rsp_last is 1 only on the second cycle of the final block.
- R8: With N = count/4, busy returns to 0 and req_ready to 1 after edge 45+4(N-1). This is 45 cycles for 4 words and 57 cycles for 16 words.
- R9: cyc_count is 0 after the taking edge and goes up by 1 on every edge while busy. It then holds the total from R8 until the next valid request is taken.
- R10: After the cycle where rsp_last is 1, req_ready stays 0 for at least two more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W (8) | Start word address; two low bits ignored |
| req_words | input | CNT_W (8) | Number of words to read |
| req_ready | output | 1 | Responder can take a request |
| req_err | output | 1 | One-cycle pulse for a rejected count |
| rsp_valid | output | 1 | A block is on rsp_data |
| rsp_data | output | 4*WORD_W (128) | Four-word block, lowest address in the low word |
| rsp_last | output | 1 | Final cycle of the final block |
| busy | output | 1 | Transaction in progress |
| cyc_count | output | CYC_W (16) | Cycles of the current or latest transaction |

## Verification
Some rules hold on every cycle and are checked by the bound assertions:
- req_ready is never 1 while busy is 1.
- rsp_last only appears together with rsp_valid.
- A block's data holds across its two cycles.
- The cycle counter starts at zero, steps by one while busy, and holds while idle.
- The two quiet cycles follow the final beat.
- An error pulse never coincides with a transfer.

Other checks need a known request and can only come from the bench's scenarios:
- The exact edge where each block appears.
- The data word pattern, including address wrap-around.
- The total lengths of 45, 57 and 293 cycles.
- Rejected counts returning nothing.
- A request offered while busy being ignored.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  localparam int BLK_WORDS = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_TAIL = 2'd2
  } seq_state_e;

endpackage

// File: rtl/burst_mem_array.sv
module burst_mem_array #(
  parameter int          WORD_W = 32,
  parameter int          BLK_AW = 6,
  parameter logic [31:0] SEED   = 32'hC0DE_0000
) (
  input  logic                                        clk,
  input  logic                                        rd_en,
  input  logic [BLK_AW-1:0]                           rd_blk,
  output logic [burst_rd_pkg::BLK_WORDS*WORD_W-1:0]   rd_q
);
  localparam int DEPTH = 1 << BLK_AW;
  localparam int ROW_W = burst_rd_pkg::BLK_WORDS * WORD_W;

  logic [ROW_W-1:0] rows [DEPTH];

  // Read-only contents computed at start-up: word a holds a ^ SEED.
  initial begin
    for (int b = 0; b < DEPTH; b++) begin
      for (int w = 0; w < burst_rd_pkg::BLK_WORDS; w++) begin
        rows[b][w*WORD_W +: WORD_W] =
          WORD_W'(b * burst_rd_pkg::BLK_WORDS + w) ^ WORD_W'(SEED);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= rows[rd_blk];
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 8,
  parameter int CYC_W     = 16,
  parameter int ADDR_CYC  = 1,
  parameter int FIRST_LAT = 40,
  parameter int NEXT_LAT  = 4,
  parameter int XFER_CYC  = 2,
  parameter int GAP_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  output logic              req_ready,
  output logic              req_err,
  output logic              busy,
  output logic [CYC_W-1:0]  cyc_count,
  output logic              fetch_en,
  output logic [ADDR_W-3:0] fetch_blk,
  output logic              load_en,
  output logic              load_final
);
  localparam int BLK_AW     = ADDR_W - 2;
  localparam int NB_W       = CNT_W - 2;
  localparam int FIRST_WAIT = ADDR_CYC + FIRST_LAT - 1;
  localparam int WAIT_W     = $clog2(FIRST_WAIT + 1);
  localparam int TAIL_LOAD  = XFER_CYC + GAP_CYC - 1;
  localparam int TAIL_W     = $clog2(TAIL_LOAD + 1);

  seq_state_e        state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [NB_W-1:0]   blk_left;
  logic [TAIL_W-1:0] tail_cnt;
  logic              accept, words_ok;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^req_addr[1:0];
  assign accept     = req_valid && req_ready;
  assign words_ok   = (req_words != '0) && (req_words[1:0] == 2'b00);
  assign fetch_en   = (state == SQ_RUN) && (wait_cnt == WAIT_W'(1));
  assign load_en    = (state == SQ_RUN) && (wait_cnt == '0);
  assign load_final = (blk_left == NB_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      req_ready <= 1'b1;
      req_err   <= 1'b0;
      busy      <= 1'b0;
      cyc_count <= '0;
      wait_cnt  <= '0;
      blk_left  <= '0;
      tail_cnt  <= '0;
      fetch_blk <= '0;
    end else begin
      req_err <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            if (words_ok) begin
              state     <= SQ_RUN;
              req_ready <= 1'b0;
              busy      <= 1'b1;
              cyc_count <= '0;
              wait_cnt  <= WAIT_W'(FIRST_WAIT);
              blk_left  <= req_words[CNT_W-1:2];
              fetch_blk <= req_addr[BLK_AW+1:2];
            end else begin
              req_err <= 1'b1;
            end
          end
        end
        SQ_RUN: begin
          cyc_count <= cyc_count + 1'b1;
          if (fetch_en) fetch_blk <= fetch_blk + 1'b1;
          if (wait_cnt == '0) begin
            blk_left <= blk_left - 1'b1;
            wait_cnt <= WAIT_W'(NEXT_LAT - 1);
            if (load_final) begin
              state    <= SQ_TAIL;
              tail_cnt <= TAIL_W'(TAIL_LOAD);
            end
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        SQ_TAIL: begin
          cyc_count <= cyc_count + 1'b1;
          if (tail_cnt == '0) begin
            state     <= SQ_IDLE;
            busy      <= 1'b0;
            req_ready <= 1'b1;
          end else begin
            tail_cnt <= tail_cnt - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_xfer_out.sv
module burst_xfer_out #(
  parameter int BLK_W    = 128,
  parameter int XFER_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             load_final,
  input  logic [BLK_W-1:0] blk_in,
  output logic             rsp_valid,
  output logic [BLK_W-1:0] rsp_data,
  output logic             rsp_last
);
  localparam int BEAT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

  logic [BEAT_W-1:0] beat;
  logic              fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
      beat      <= '0;
      fin       <= 1'b0;
    end else if (load_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= blk_in;
      beat      <= BEAT_W'(XFER_CYC - 1);
      fin       <= load_final;
      rsp_last  <= load_final && (XFER_CYC == 1);
    end else if (rsp_valid) begin
      if (beat == '0) begin
        rsp_valid <= 1'b0;
        rsp_last  <= 1'b0;
      end else begin
        beat     <= beat - 1'b1;
        rsp_last <= fin && (beat == BEAT_W'(1));
      end
    end
  end
endmodule

// File: rtl/burst_rd_responder.sv
module burst_rd_responder
  import burst_rd_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter int          CNT_W     = 8,
  parameter int          CYC_W     = 16,
  parameter int          ADDR_CYC  = 1,
  parameter int          FIRST_LAT = 40,
  parameter int          NEXT_LAT  = 4,
  parameter int          XFER_CYC  = 2,
  parameter int          GAP_CYC   = 2,
  parameter logic [31:0] SEED      = 32'hC0DE_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [CNT_W-1:0]              req_words,
  output logic                          req_ready,
  output logic                          req_err,
  output logic                          rsp_valid,
  output logic [BLK_WORDS*WORD_W-1:0]   rsp_data,
  output logic                          rsp_last,
  output logic                          busy,
  output logic [CYC_W-1:0]              cyc_count
);
  localparam int BLK_W  = BLK_WORDS * WORD_W;
  localparam int BLK_AW = ADDR_W - 2;

  logic              fetch_en, load_en, load_final;
  logic [BLK_AW-1:0] fetch_blk;
  logic [BLK_W-1:0]  mem_q;

  burst_rd_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CYC_W(CYC_W), .ADDR_CYC(ADDR_CYC),
    .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT), .XFER_CYC(XFER_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .req_ready(req_ready), .req_err(req_err),
    .busy(busy), .cyc_count(cyc_count), .fetch_en(fetch_en),
    .fetch_blk(fetch_blk), .load_en(load_en), .load_final(load_final)
  );

  burst_mem_array #(.WORD_W(WORD_W), .BLK_AW(BLK_AW), .SEED(SEED)) u_mem (
    .clk(clk), .rd_en(fetch_en), .rd_blk(fetch_blk), .rd_q(mem_q)
  );

  burst_xfer_out #(.BLK_W(BLK_W), .XFER_CYC(XFER_CYC)) u_out (
    .clk(clk), .rst(rst), .load_en(load_en), .load_final(load_final),
    .blk_in(mem_q), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last)
  );
endmodule

// File: rtl/burst_rd_checker.sv
module burst_rd_checker #(
  parameter int DATA_W = 128,
  parameter int CYC_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_err,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_last,
  input logic              busy,
  input logic [CYC_W-1:0]  cyc_count
);
  a_r2_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  a_r3_err_without_transfer: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && !rsp_valid));

  a_r5_block_held: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |=> (rsp_valid && $stable(rsp_data)));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);

  a_r9_count_starts_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cyc_count == '0));

  a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cyc_count == $past(cyc_count) + 1'b1));

  a_r9_count_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && req_ready)) |=> $stable(cyc_count));

  a_r10_gap_first: assert property (@(posedge clk) disable iff (rst)
    rsp_last |=> !req_ready);

  a_r10_gap_second: assert property (@(posedge clk) disable iff (rst)
    rsp_last |=> ##1 !req_ready);
endmodule

bind burst_rd_responder burst_rd_checker #(
  .DATA_W(BLK_WORDS * WORD_W), .CYC_W(CYC_W)
) u_chk (.*);

// File: tb/burst_rd_responder_test.sv
module burst_rd_responder_test;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int CYC_W  = 16;
  localparam int FIRST_EDGE = 41;   // R4: address cycle + first access
  localparam int STEP       = 4;    // R5
  localparam int NVEC       = 9;

  // {addr[7:0], words[7:0], reject, total[15:0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {8'd0,   8'd4,   1'b0, 16'd45},
    {8'd16,  8'd16,  1'b0, 16'd57},
    {8'd40,  8'd8,   1'b0, 16'd49},
    {8'd250, 8'd16,  1'b0, 16'd57},
    {8'd7,   8'd12,  1'b0, 16'd53},
    {8'd100, 8'd0,   1'b1, 16'd0},
    {8'd8,   8'd6,   1'b1, 16'd0},
    {8'd12,  8'd3,   1'b1, 16'd0},
    {8'd1,   8'd252, 1'b0, 16'd293}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst = 1'b1;
  logic                  req_valid = 1'b0;
  logic [ADDR_W-1:0]     req_addr = '0;
  logic [CNT_W-1:0]      req_words = '0;
  logic                  req_ready, req_err, rsp_valid, rsp_last, busy;
  logic [4*WORD_W-1:0]   rsp_data;
  logic [CYC_W-1:0]      cyc_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  burst_rd_responder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .req_ready(req_ready), .req_err(req_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .busy(busy), .cyc_count(cyc_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_word(input int a);
    return 32'((a & 255)) ^ 32'hC0DE_0000;   // R6
  endfunction

  task automatic check_reset_state();       // R1
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(rsp_last == 1'b0, "R1", "rsp_last", rsp_last, 0);
    chk(req_err == 1'b0, "R1", "req_err", req_err, 0);
    chk(cyc_count == '0, "R1", "cyc_count", cyc_count, 0);
  endtask

  // hold_busy: keep offering a different request while busy (R2)
  task automatic run_req(input int addr, input int words, input bit reject,
                         input int total, input bit hold_busy);
    int nb, base;
    logic [CYC_W-1:0] prev_cnt;
    nb = words / 4;
    base = addr & ~3;
    prev_cnt = cyc_count;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_words = CNT_W'(words);
    @(posedge clk);                       // taking edge: edge 0
    @(negedge clk);
    if (hold_busy) begin
      req_addr = 8'd200; req_words = 8'd8;
    end else begin
      req_valid = 1'b0;
    end
    if (reject) begin
      chk(req_err == 1'b1, "R3", "err pulse", req_err, 1);
      chk(busy == 1'b0 && req_ready == 1'b1, "R3", "busy/ready",
          {busy, req_ready}, 2'b01);
      for (int e = 1; e <= 50; e++) begin
        @(negedge clk);
        chk(req_err == 1'b0, "R3", "err width", req_err, 0);
        chk(rsp_valid == 1'b0 && busy == 1'b0, "R3", "no data",
            {rsp_valid, busy}, 0);
      end
      chk(cyc_count == prev_cnt, "R3", "count kept", cyc_count, prev_cnt);
    end else begin
      chk(busy == 1'b1 && req_ready == 1'b0, "R2", "busy/ready after take",
          {busy, req_ready}, 2'b10);
      chk(cyc_count == '0, "R9", "count cleared", cyc_count, 0);
      for (int e = 1; e <= total + 3; e++) begin
        bit ev, el;
        int k, off;
        @(negedge clk);
        if (hold_busy && e == 30) req_valid = 1'b0;
        off = e - FIRST_EDGE;
        k = (off >= 0) ? off / STEP : 0;
        ev = (off >= 0) && (k < nb) && ((off % STEP) < 2);
        el = (e == FIRST_EDGE + 1 + STEP * (nb - 1));
        chk(rsp_valid == ev, (k == 0) ? "R4" : "R5", "rsp_valid", rsp_valid, ev);
        chk(rsp_last == el, "R7", "rsp_last", rsp_last, el);
        if (ev && rsp_valid) begin
          for (int w = 0; w < 4; w++) begin
            chk(rsp_data[w*32 +: 32] == exp_word(base + 4*k + w), "R6", "word",
                rsp_data[w*32 +: 32], exp_word(base + 4*k + w));
          end
        end
        chk(busy == (e < total), "R8", "busy", busy, (e < total));
        chk(req_ready == (e >= total),
            (e > FIRST_EDGE + 1 + STEP * (nb - 1) && e < total) ? "R10" : "R8",
            "req_ready", req_ready, (e >= total));
        chk(cyc_count == CYC_W'((e < total) ? e : total), "R9", "cyc_count",
            cyc_count, (e < total) ? e : total);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();                  // R1

    for (int i = 0; i < NVEC; i++) begin
      run_req(int'(VEC[i][32:25]), int'(VEC[i][24:17]), VEC[i][16],
              int'(VEC[i][15:0]), 1'b0);
    end

    // R2: a second request offered while busy is ignored
    run_req(32, 4, 1'b0, 45, 1'b1);

    // R1: reset in the middle of a transaction
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'd64; req_words = 8'd16;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    // recovery after reset, 16 words from address 128
    run_req(128, 16, 1'b0, 57, 1'b0);
    report();
  end
endmodule